// File: doc/BRIEF.md
# SPI Slave Banked Memory Access Controller

This block is a serial-peripheral slave front end that turns a byte stream on a four-wire SPI link into core-side actions. After chip select falls, the first byte chooses one of three operations. It can fire a one-cycle command strobe, run a 16-bit register transfer on a register-file port, or open a multi-byte session into an on-chip RAM. The RAM holds two 128-byte FIFO data banks and one 112-byte security bank. Strobes and register transfers finish by themselves, so several of them can be sent back to back inside one chip-select window. A RAM session keeps running until chip select rises.

SCLK, SI and the chip select are synchronised to the system clock and handled in SPI mode 0. SI is taken on rising SCLK, SO moves on falling SCLK, and bytes go most significant bit first. A RAM session takes a second header byte that selects the bank and a read-only flag. The address then steps forward on each data byte. In a writing session, each data byte returns the old content of the location it overwrites. RAM writes are plain memory writes and have no side effect on any fill counter.

Top module: `spi_bank_ctrl`

## Requirements
- R1: First command byte: bit 7 = 1 opens a RAM session and bit 7 = 0 a register or strobe access. For a register access, bits 5:0 are the register address and bit 6 = 1 marks a read.
- R2: A register-class command whose address (bits 5:0) is below STROBE_LIMIT (default 16) gives exactly one single-cycle strobe_pulse with strobe_addr equal to that address. It starts no register transfer.
- R3: Any other register-class command with bit 6 = 0 takes two data bytes, high byte first. It then gives one reg_we pulse with reg_wdata = {high, low}. While those two bytes come in, SO returns the register's prior value, high byte first.
- R4: With bit 6 = 1, SO returns reg_rdata (high byte, then low byte) on the two bytes after the command and no write happens. Raising chip select after the high byte ends the read, again with no write.
- R5: Strobes and register accesses end on their last bit. The next byte in the same chip-select window is a new command byte.
- R6: RAM header byte: bits 7:6 are the bank, bit 5 = 1 marks read-only, and bits 4:0 are ignored. The byte address is bank*128 + (first byte bits 6:0).
- R7: In a writing RAM session, each data byte is stored at the current address and the address then steps by one. SO returns the old content of that address during the same byte.
- R8: In a read-only RAM session, SO returns consecutive bytes from the start address and the RAM contents stay unchanged.
- R9: The address steps linearly across bank boundaries, modulo 512. Offsets 112..127 of bank 2, and all of bank 3, read as 0x00 and discard writes.
- R10: A RAM session, or a byte that is only partly shifted, ends only when chip select rises. The first byte of the next window is decoded as a command.
- R11: SO is 0 while chip select is high, and it is 0 during the first byte of every window and during the byte after each completed command.
- R12: After reset, SO, strobe_pulse, reg_we and reg_re are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| csn | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| strobe_pulse | output | 1 | One-cycle command strobe |
| strobe_addr | output | REG_AW | Address of the strobe |
| reg_addr | output | REG_AW | Register-file address |
| reg_wdata | output | 16 | Register write data |
| reg_we | output | 1 | Register write pulse |
| reg_re | output | 1 | Register read pulse; reg_rdata is sampled in this cycle |
| reg_rdata | input | 16 | Register read data, combinational from reg_addr |

## Verification
A rising SCLK edge reaches the byte logic after the two synchroniser stages. The finished byte is flagged one clock later, and strobe_pulse, reg_we or a RAM write follows one clock after that, so all of them land within five system clocks of the last rising SCLK edge. SO for each bit is updated within four clocks of the falling SCLK edge. The bench holds each SCLK phase for eight system clocks, so its monitor samples SO on the rising SCLK edge, long after the value settles. Register, strobe and RAM effects are checked only after chip select has been high for several half-periods. Every expected SO byte is queued by the driver at the moment it sends the matching SI byte, so scoreboard order follows byte order on the link.

// File: rtl/spi_bank_pkg.sv
package spi_bank_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_CMD      = 3'd0,
      ST_REG_HI   = 3'd1,
      ST_REG_LO   = 3'd2,
      ST_RAM_HDR  = 3'd3,
      ST_RAM_DATA = 3'd4
   } link_state_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pin_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_act,
   input  logic         sclk_s,
   input  logic         si_s,
   input  logic [W-1:0] tx_byte,
   output logic [W-1:0] rx_byte,
   output logic         rx_valid,
   output logic         so
);

   localparam int CNT_W = (W > 2) ? $clog2(W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

   if (W < 2) begin : g_bad_w
      $error("spi_byte_shifter width must be at least two");
   end

   logic             sclk_q;
   logic             rise, fall;
   logic [CNT_W-1:0] bit_cnt;
   logic [W-1:0]     rx_sr;
   logic [W-1:0]     tx_sr;

   assign rise = cs_act &  sclk_s & ~sclk_q;
   assign fall = cs_act & ~sclk_s &  sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         rx_sr    <= '0;
         rx_byte  <= '0;
         rx_valid <= 1'b0;
         tx_sr    <= '0;
         so       <= 1'b0;
      end else if (!cs_act) begin
         bit_cnt  <= '0;
         rx_valid <= 1'b0;
         tx_sr    <= '0;
         so       <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (rise) begin
            rx_sr <= {rx_sr[W-2:0], si_s};
            if (bit_cnt == LAST_BIT) begin
               bit_cnt  <= '0;
               rx_byte  <= {rx_sr[W-2:0], si_s};
               rx_valid <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
         if (fall) begin
            if (bit_cnt == '0) begin
               so    <= tx_byte[W-1];
               tx_sr <= {tx_byte[W-2:0], 1'b0};
            end else begin
               so    <= tx_sr[W-1];
               tx_sr <= {tx_sr[W-2:0], 1'b0};
            end
         end
      end
   end

endmodule

// File: rtl/spi_bank_ram.sv
module spi_bank_ram #(
   parameter int BANK_BYTES = 128,
   parameter int SEC_BYTES  = 112,
   parameter int NUM_BANKS  = 3,
   parameter int BANK_W     = 2
) (
   input  logic                                   clk,
   input  logic                                   we,
   input  logic [BANK_W+$clog2(BANK_BYTES)-1:0]   waddr,
   input  logic [7:0]                             wdata,
   input  logic [BANK_W+$clog2(BANK_BYTES)-1:0]   raddr,
   output logic [7:0]                             rdata
);

   localparam int OFF_W = $clog2(BANK_BYTES);
   localparam int AW    = BANK_W + OFF_W;

   if (NUM_BANKS > (1 << BANK_W)) begin : g_bad_banks
      $error("spi_bank_ram bank count exceeds bank field");
   end
   if (SEC_BYTES > BANK_BYTES) begin : g_bad_sec
      $error("spi_bank_ram last bank larger than a full bank");
   end

   logic [7:0] rd_bank [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int DEPTH = (b == NUM_BANKS - 1) ? SEC_BYTES : BANK_BYTES;
      localparam logic [BANK_W-1:0] ID    = BANK_W'(b);
      localparam logic [OFF_W:0]    LIMIT = (OFF_W + 1)'(DEPTH);

      logic [7:0] mem [DEPTH];
      logic       w_hit, r_hit;

      assign w_hit = we && (waddr[AW-1:OFF_W] == ID) &&
                     ({1'b0, waddr[OFF_W-1:0]} < LIMIT);
      assign r_hit = (raddr[AW-1:OFF_W] == ID) &&
                     ({1'b0, raddr[OFF_W-1:0]} < LIMIT);

      always_ff @(posedge clk) begin
         if (w_hit) mem[waddr[OFF_W-1:0]] <= wdata;
      end

      assign rd_bank[b] = r_hit ? mem[raddr[OFF_W-1:0]] : 8'h00;
   end

   always_comb begin
      rdata = 8'h00;
      for (int i = 0; i < NUM_BANKS; i++) rdata = rdata | rd_bank[i];
   end

endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
   import spi_bank_pkg::*;
#(
   parameter int REG_AW       = 6,
   parameter int REG_DW       = 16,
   parameter int STROBE_LIMIT = 16,
   parameter int RAM_AW       = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic [7:0]        rx_byte,
   input  logic              rx_valid,
   output logic [7:0]        tx_byte,
   output logic              strobe_pulse,
   output logic [REG_AW-1:0] strobe_addr,
   output logic [REG_AW-1:0] reg_addr,
   output logic [REG_DW-1:0] reg_wdata,
   output logic              reg_we,
   output logic              reg_re,
   input  logic [REG_DW-1:0] reg_rdata,
   output logic [RAM_AW-1:0] ram_raddr,
   output logic [RAM_AW-1:0] ram_waddr,
   output logic [7:0]        ram_wdata,
   output logic              ram_we,
   input  logic [7:0]        ram_rdata
);

   localparam logic [REG_AW-1:0] STROBE_LIM_V = REG_AW'(STROBE_LIMIT);
   localparam int LO_W = RAM_AW - 2;

   if (REG_DW != 2 * BYTE_W) begin : g_bad_dw
      $error("spi_cmd_fsm register width must be two bytes");
   end
   if (REG_AW > 6) begin : g_bad_aw
      $error("spi_cmd_fsm register address must fit bits 5:0");
   end
   if (LO_W != 7) begin : g_bad_ram_aw
      $error("spi_cmd_fsm RAM offset must be seven bits");
   end

   link_state_e       state;
   logic              rd_mode;
   logic              ro_mode;
   logic              load_tx;
   logic [7:0]        hi_byte;
   logic [7:0]        rd_lo;
   logic [LO_W-1:0]   ram_lo;
   logic [RAM_AW-1:0] ptr;

   assign ram_raddr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_CMD;
         rd_mode      <= 1'b0;
         ro_mode      <= 1'b0;
         load_tx      <= 1'b0;
         hi_byte      <= '0;
         rd_lo        <= '0;
         ram_lo       <= '0;
         ptr          <= '0;
         tx_byte      <= '0;
         strobe_pulse <= 1'b0;
         strobe_addr  <= '0;
         reg_addr     <= '0;
         reg_wdata    <= '0;
         reg_we       <= 1'b0;
         reg_re       <= 1'b0;
         ram_waddr    <= '0;
         ram_wdata    <= '0;
         ram_we       <= 1'b0;
      end else if (!cs_act) begin
         state        <= ST_CMD;
         load_tx      <= 1'b0;
         tx_byte      <= '0;
         strobe_pulse <= 1'b0;
         reg_we       <= 1'b0;
         reg_re       <= 1'b0;
         ram_we       <= 1'b0;
      end else begin
         strobe_pulse <= 1'b0;
         reg_we       <= 1'b0;
         reg_re       <= 1'b0;
         ram_we       <= 1'b0;
         load_tx      <= 1'b0;

         if (load_tx) tx_byte <= ram_rdata;

         if (reg_re) begin
            tx_byte <= reg_rdata[REG_DW-1:BYTE_W];
            rd_lo   <= reg_rdata[BYTE_W-1:0];
         end

         if (rx_valid) begin
            unique case (state)
               ST_CMD: begin
                  tx_byte <= '0;
                  if (rx_byte[7]) begin
                     ram_lo <= rx_byte[LO_W-1:0];
                     state  <= ST_RAM_HDR;
                  end else if (rx_byte[REG_AW-1:0] < STROBE_LIM_V) begin
                     strobe_pulse <= 1'b1;
                     strobe_addr  <= rx_byte[REG_AW-1:0];
                  end else begin
                     reg_addr <= rx_byte[REG_AW-1:0];
                     rd_mode  <= rx_byte[6];
                     reg_re   <= 1'b1;
                     state    <= ST_REG_HI;
                  end
               end
               ST_REG_HI: begin
                  hi_byte <= rx_byte;
                  tx_byte <= rd_lo;
                  state   <= ST_REG_LO;
               end
               ST_REG_LO: begin
                  if (!rd_mode) begin
                     reg_we    <= 1'b1;
                     reg_wdata <= {hi_byte, rx_byte};
                  end
                  tx_byte <= '0;
                  state   <= ST_CMD;
               end
               ST_RAM_HDR: begin
                  ptr     <= {rx_byte[7:6], ram_lo};
                  ro_mode <= rx_byte[5];
                  load_tx <= 1'b1;
                  state   <= ST_RAM_DATA;
               end
               ST_RAM_DATA: begin
                  if (!ro_mode) begin
                     ram_we    <= 1'b1;
                     ram_waddr <= ptr;
                     ram_wdata <= rx_byte;
                  end
                  ptr     <= ptr + 1'b1;
                  load_tx <= 1'b1;
               end
               default: state <= ST_CMD;
            endcase
         end
      end
   end

endmodule

// File: rtl/spi_bank_ctrl.sv
module spi_bank_ctrl
   import spi_bank_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int REG_AW       = 6,
   parameter int STROBE_LIMIT = 16,
   parameter int BANK_BYTES   = 128,
   parameter int SEC_BYTES    = 112,
   parameter int NUM_BANKS    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              csn,
   input  logic              si,
   output logic              so,
   output logic              strobe_pulse,
   output logic [REG_AW-1:0] strobe_addr,
   output logic [REG_AW-1:0] reg_addr,
   output logic [15:0]       reg_wdata,
   output logic              reg_we,
   output logic              reg_re,
   input  logic [15:0]       reg_rdata
);

   localparam int BANK_W = 2;
   localparam int RAM_AW = BANK_W + $clog2(BANK_BYTES);

   if (STROBE_LIMIT > (1 << REG_AW)) begin : g_bad_limit
      $error("spi_bank_ctrl strobe limit exceeds register space");
   end

   logic sclk_s, csn_s, si_s, cs_act;

   spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
      .clk(clk), .rst_n(rst_n), .d(csn), .q(csn_s));
   spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_si (
      .clk(clk), .rst_n(rst_n), .d(si), .q(si_s));

   assign cs_act = ~csn_s;

   logic [7:0]        rx_byte, tx_byte;
   logic              rx_valid;
   logic [RAM_AW-1:0] ram_raddr, ram_waddr;
   logic [7:0]        ram_wdata, ram_rdata;
   logic              ram_we;

   spi_byte_shifter #(.W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_s(sclk_s),
      .si_s(si_s), .tx_byte(tx_byte), .rx_byte(rx_byte),
      .rx_valid(rx_valid), .so(so));

   spi_cmd_fsm #(
      .REG_AW(REG_AW), .REG_DW(16),
      .STROBE_LIMIT(STROBE_LIMIT), .RAM_AW(RAM_AW)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_byte(tx_byte),
      .strobe_pulse(strobe_pulse), .strobe_addr(strobe_addr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
      .ram_raddr(ram_raddr), .ram_waddr(ram_waddr),
      .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata));

   spi_bank_ram #(
      .BANK_BYTES(BANK_BYTES), .SEC_BYTES(SEC_BYTES),
      .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
   ) u_ram (
      .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
      .raddr(ram_raddr), .rdata(ram_rdata));

endmodule

// File: rtl/spi_bank_ctrl_chk.sv
module spi_bank_ctrl_chk #(
   parameter int REG_AW       = 6,
   parameter int STROBE_LIMIT = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csn,
   input logic              so,
   input logic              cs_act,
   input logic              strobe_pulse,
   input logic [REG_AW-1:0] strobe_addr,
   input logic [REG_AW-1:0] reg_addr,
   input logic              reg_we,
   input logic              reg_re,
   input logic              ram_we
);

   localparam logic [REG_AW-1:0] LIM = REG_AW'(STROBE_LIMIT);

   // R2
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_pulse |=> !strobe_pulse);

   // R2
   strobe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_pulse |-> (strobe_addr < LIM));

   // R3
   regwe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (reg_addr >= LIM));

   // R4
   regre_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);

   // R5
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({strobe_pulse, reg_we, reg_re}));

   // R10
   ram_write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> $past(cs_act));

   // R11
   so_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csn && $past(csn) && $past(csn, 2) && $past(csn, 3) && $past(csn, 4))
      |-> !so);

endmodule

bind spi_bank_ctrl spi_bank_ctrl_chk #(
   .REG_AW(REG_AW), .STROBE_LIMIT(STROBE_LIMIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .csn(csn), .so(so), .cs_act(cs_act),
   .strobe_pulse(strobe_pulse), .strobe_addr(strobe_addr),
   .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
   .ram_we(ram_we));

// File: tb/tb_spi_bank_ctrl.sv
module tb_spi_bank_ctrl;

   localparam int HP = 8;

   logic        clk = 1'b0;
   logic        rst_n, sclk, csn, si;
   logic        so, strobe_pulse, reg_we, reg_re;
   logic [5:0]  strobe_addr, reg_addr;
   logic [15:0] reg_wdata, reg_rdata;

   always #2 clk = ~clk;

   spi_bank_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .si(si), .so(so),
      .strobe_pulse(strobe_pulse), .strobe_addr(strobe_addr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .reg_re(reg_re), .reg_rdata(reg_rdata));

   int checks = 0;
   int errors = 0;
   logic [15:0] regs [64];
   int          we_cnt;
   logic [5:0]  strobe_log [$];
   logic [8:0]  exp_q [$];
   string       tag_q [$];

   always_comb reg_rdata = regs[reg_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) regs[i] <= 16'h1000 + 16'(i);
         we_cnt = 0;
      end else begin
         if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
            we_cnt = we_cnt + 1;
         end
         if (strobe_pulse) strobe_log.push_back(strobe_addr);
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // scoreboard monitor: assembles SO bytes and compares in order
   int         mcnt;
   logic [7:0] msh;
   always @(posedge sclk or posedge csn) begin
      if (csn) begin
         mcnt = 0;
      end else begin
         msh  = {msh[6:0], so};
         mcnt = mcnt + 1;
         if (mcnt == 8) begin
            mcnt = 0;
            if (exp_q.size() == 0) begin
               check(1'b0, "R11", "unexpected SO byte", int'(msh), 0);
            end else begin
               logic [8:0] e;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (e[8]) check(msh == e[7:0], t, "SO byte", int'(msh), int'(e[7:0]));
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_on();
      csn = 1'b0;
      tick(HP);
   endtask

   task automatic cs_off();
      tick(HP);
      csn = 1'b1;
      tick(4 * HP);
   endtask

   task automatic send_bits(input logic [7:0] d, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         si = d[i];
         tick(HP);
         sclk = 1'b1;
         tick(HP);
         sclk = 1'b0;
      end
   endtask

   // driver: pushes the expected SO byte, then shifts the SI byte
   task automatic xb(input logic [7:0] d, input logic [8:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      send_bits(d, 8);
   endtask

   function automatic logic [8:0] C(input logic [7:0] v);
      return {1'b1, v};
   endfunction

   localparam logic [8:0] DC = 9'h000;

   initial begin
      int base;
      rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; si = 1'b0;
      tick(10);
      rst_n = 1'b1;
      tick(4);
      // R12 reset state
      check(so == 1'b0, "R12", "so after reset", int'(so), 0);
      check(strobe_pulse == 1'b0, "R12", "strobe after reset", int'(strobe_pulse), 0);
      check(reg_we == 1'b0 && reg_re == 1'b0, "R12", "reg pulses after reset",
            int'({reg_we, reg_re}), 0);

      // R2 single strobe
      cs_on(); xb(8'h03, C(8'h00), "R11"); cs_off();
      check(strobe_log.size() == 1, "R2", "strobe count", strobe_log.size(), 1);
      if (strobe_log.size() > 0) begin
         logic [5:0] a;
         a = strobe_log.pop_front();
         check(a == 6'd3, "R2", "strobe addr", int'(a), 3);
      end

      // R1 R3 register write, old value returned
      cs_on();
      xb(8'h25, C(8'h00), "R11");
      xb(8'hBE, C(8'h10), "R3");
      xb(8'hEF, C(8'h25), "R3");
      cs_off();
      check(regs[37] == 16'hBEEF, "R1", "register 37 written", int'(regs[37]), 16'hBEEF);
      check(we_cnt == 1, "R3", "write pulse count", we_cnt, 1);

      // R5 chain: two strobes, a read and a write in one window
      cs_on();
      xb(8'h05, C(8'h00), "R11");
      xb(8'h07, C(8'h00), "R5");
      xb(8'h65, C(8'h00), "R5");
      xb(8'h00, C(8'hBE), "R4");
      xb(8'h00, C(8'hEF), "R4");
      xb(8'h26, C(8'h00), "R11");
      xb(8'h12, C(8'h10), "R5");
      xb(8'h34, C(8'h26), "R5");
      cs_off();
      check(strobe_log.size() == 2, "R5", "chained strobe count", strobe_log.size(), 2);
      if (strobe_log.size() == 2) begin
         logic [5:0] a0, a1;
         a0 = strobe_log.pop_front();
         a1 = strobe_log.pop_front();
         check(a0 == 6'd5 && a1 == 6'd7, "R5", "chained strobe order",
               int'({a0, a1}), int'({6'd5, 6'd7}));
      end
      check(regs[38] == 16'h1234, "R5", "chained write", int'(regs[38]), 16'h1234);
      check(we_cnt == 2, "R4", "read made no write", we_cnt, 2);

      // R4 read cut after high byte
      cs_on();
      xb(8'h66, C(8'h00), "R11");
      xb(8'h00, C(8'h12), "R4");
      cs_off();
      check(we_cnt == 2, "R4", "short read no write", we_cnt, 2);
      check(regs[38] == 16'h1234, "R4", "register kept", int'(regs[38]), 16'h1234);
      check(so == 1'b0, "R11", "so idle", int'(so), 0);

      // R6 R7 RAM write bank 0, junk in header low bits
      cs_on();
      xb(8'h85, C(8'h00), "R11"); xb(8'h1F, C(8'h00), "R11");
      xb(8'h11, DC, "R7"); xb(8'h22, DC, "R7"); xb(8'h33, DC, "R7");
      cs_off();
      // R8 read-only returns data and leaves it alone
      cs_on();
      xb(8'h85, C(8'h00), "R11"); xb(8'h3F, C(8'h00), "R11");
      xb(8'hFF, C(8'h11), "R8"); xb(8'hFF, C(8'h22), "R8"); xb(8'hFF, C(8'h33), "R8");
      cs_off();
      cs_on();
      xb(8'h85, C(8'h00), "R11"); xb(8'h20, C(8'h00), "R11");
      xb(8'h00, C(8'h11), "R8"); xb(8'h00, C(8'h22), "R8"); xb(8'h00, C(8'h33), "R8");
      cs_off();
      // R7 overwrite returns old bytes
      cs_on();
      xb(8'h85, C(8'h00), "R11"); xb(8'h00, C(8'h00), "R11");
      xb(8'hAA, C(8'h11), "R7"); xb(8'hBB, C(8'h22), "R7");
      cs_off();
      cs_on();
      xb(8'h85, C(8'h00), "R11"); xb(8'h20, C(8'h00), "R11");
      xb(8'h00, C(8'hAA), "R7"); xb(8'h00, C(8'hBB), "R7"); xb(8'h00, C(8'h33), "R7");
      cs_off();

      // R6 bank select keeps banks apart
      cs_on(); xb(8'h85, C(8'h00), "R11"); xb(8'h40, C(8'h00), "R11");
      xb(8'h77, DC, "R6"); cs_off();
      cs_on(); xb(8'h85, C(8'h00), "R11"); xb(8'h80, C(8'h00), "R11");
      xb(8'h99, DC, "R6"); cs_off();
      cs_on(); xb(8'h85, C(8'h00), "R11"); xb(8'h20, C(8'h00), "R11");
      xb(8'h00, C(8'hAA), "R6"); cs_off();
      cs_on(); xb(8'h85, C(8'h00), "R11"); xb(8'h60, C(8'h00), "R11");
      xb(8'h00, C(8'h77), "R6"); cs_off();
      cs_on(); xb(8'h85, C(8'h00), "R11"); xb(8'hA0, C(8'h00), "R11");
      xb(8'h00, C(8'h99), "R6"); cs_off();

      // R9 unmapped tail of bank 2 and bank 3
      cs_on(); xb(8'hEF, C(8'h00), "R11"); xb(8'h80, C(8'h00), "R11");
      xb(8'h01, DC, "R9"); xb(8'h02, C(8'h00), "R9"); cs_off();
      cs_on(); xb(8'hEF, C(8'h00), "R11"); xb(8'hA0, C(8'h00), "R11");
      xb(8'h00, C(8'h01), "R9"); xb(8'h00, C(8'h00), "R9"); cs_off();
      cs_on(); xb(8'h81, C(8'h00), "R11"); xb(8'hC0, C(8'h00), "R11");
      xb(8'h55, C(8'h00), "R9"); cs_off();
      cs_on(); xb(8'h81, C(8'h00), "R11"); xb(8'hE0, C(8'h00), "R11");
      xb(8'h00, C(8'h00), "R9"); cs_off();

      // R9 increment crosses from bank 0 into bank 1
      cs_on(); xb(8'hFF, C(8'h00), "R11"); xb(8'h00, C(8'h00), "R11");
      xb(8'h5C, DC, "R9"); xb(8'h6D, DC, "R9"); cs_off();
      cs_on(); xb(8'h80, C(8'h00), "R11"); xb(8'h60, C(8'h00), "R11");
      xb(8'h00, C(8'h6D), "R9"); cs_off();

      // R10 RAM session ends at chip select; next byte is a command
      cs_on(); xb(8'h90, C(8'h00), "R11"); xb(8'h00, C(8'h00), "R11");
      xb(8'h42, DC, "R10"); xb(8'h43, DC, "R10"); cs_off();
      cs_on(); xb(8'h09, C(8'h00), "R10"); cs_off();
      check(strobe_log.size() == 1, "R10", "command after RAM window",
            strobe_log.size(), 1);
      if (strobe_log.size() > 0) begin
         logic [5:0] a;
         a = strobe_log.pop_front();
         check(a == 6'd9, "R10", "strobe addr after RAM window", int'(a), 9);
      end
      cs_on(); xb(8'h90, C(8'h00), "R11"); xb(8'h20, C(8'h00), "R11");
      xb(8'h00, C(8'h42), "R10"); xb(8'h00, C(8'h43), "R10"); cs_off();

      // R10 partial byte discarded, next window decodes cleanly
      base = we_cnt;
      cs_on(); send_bits(8'h2A, 4); cs_off();
      cs_on();
      xb(8'h2A, C(8'h00), "R11"); xb(8'h01, C(8'h10), "R10"); xb(8'h02, C(8'h2A), "R10");
      cs_off();
      check(we_cnt == base + 1, "R10", "one write after abort", we_cnt, base + 1);
      check(regs[42] == 16'h0102, "R10", "register 42 written", int'(regs[42]), 16'h0102);

      check(exp_q.size() == 0, "R11", "scoreboard drained", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R12", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule